// File: doc/BRIEF.md
# Memory data-bus integrity sequencer

This block takes charge of a synchronous single-port memory with a 64-bit data word and checks that the data bus is sound. It draws twelve words from a fixed set of adjacency patterns. Across the set, every pair of data lines is driven to opposite values at least once, however the lines are routed on the board. For each pattern the block writes the word to a target location. It then writes a fixed filler word to the location just above, so that a floating bus is recharged to a different value. Only after that does it read the target, exactly once, and compare.

A single-cycle start pulse latches the target address and launches a run. The run always applies all twelve patterns. Busy covers the whole run, and a one-cycle done pulse marks its end. A sticky fail flag is held with three capture registers, which keep the address, the expected word and the word read for the first mismatch only. The memory side uses a request/valid protocol: a read request is answered by a data-valid strobe, and the block waits for that strobe before it compares.

Top module: `dataline_tester`

## Requirements
- R1: After reset, busy, done and fail are 0, the capture registers are 0, and mem_req stays 0 until a start pulse arrives.
- R2: A run applies twelve patterns in this order: AAAAAAAAAAAAAAAA, CCCCCCCCCCCCCCCC, F0F0F0F0F0F0F0F0, FF00FF00FF00FF00, FFFF0000FFFF0000, FFFFFFFF00000000, and then the bitwise complements of those six in the same order (all values hex).
- R3: Each pattern uses exactly three requests in this order:
  - a write of the pattern to the target address (mem_we=1);
  - a write of 0123456789ABCDEF to the target address plus one (mem_we=1);
  - one read of the target address (mem_we=0).
- R4: After a read request, no further request is issued until mem_rvalid returns the read data, whatever the added latency.
- R5: A mismatch does not end the run. All twelve patterns (36 requests) are always issued.
- R6: fail rises when a compare mismatches and stays 1 until the next accepted start pulse, which clears it.
- R7: On the first mismatch of a run, fail_addr takes the target address, fail_expected takes the pattern and fail_actual takes the single value read. Later mismatches leave these registers unchanged. An accepted start clears them to 0.
- R8: Done is high for exactly one cycle, in the cycle after the twelfth read data arrives. Busy is 0 in that same cycle and is 1 from the cycle after an accepted start.
- R9: A start pulse while busy is ignored. The run continues on its original target, and only one done pulse is produced.
- R10: The target address is taken from base_addr in the cycle start is accepted, and later changes of base_addr do not affect the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| base_addr | input | ADDR_W | Target word address, latched at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ADDR_W | Target address of the first mismatch |
| fail_expected | output | 64 | Pattern of the first mismatch |
| fail_actual | output | 64 | Word read in the first mismatch |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request word address |
| mem_wdata | output | 64 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |

## Verification
Two cases put a pair of functions into the same cycle.

In the first, a stuck-low bit makes every complement pattern fail, including the twelfth. The last mismatch, which must leave the captured values alone, is therefore judged at the same edge that raises done and drops busy. The bench checks that the capture still holds the sixth-index pattern and that done lasts one cycle with busy low.

In the second, a start pulse is driven in the middle of a run, while requests are being issued. It must be ignored: every recorded target address must stay the original one, and exactly one done pulse must appear.

A floating-bus model, where a read returns the last word written, combined with extra read latency shows that the filler write separates the pattern from its readback.

// File: rtl/dlt_pkg.sv
package dlt_pkg;
    localparam int DATA_W   = 64;
    localparam int NUM_PAT  = 12;
    localparam int BASE_PAT = NUM_PAT / 2;
    localparam int IDX_W    = $clog2(NUM_PAT);
    localparam int SEL_W    = $clog2(BASE_PAT);
    localparam logic [DATA_W-1:0] FILLER_WORD = 64'h0123_4567_89AB_CDEF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_PAT,
        ST_WR_FILL,
        ST_RD_REQ,
        ST_RD_WAIT
    } seq_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] expected;
        logic [DATA_W-1:0] actual;
    } cmp_pair_t;
endpackage

// File: rtl/dlt_pattern_gen.sv
module dlt_pattern_gen
    import dlt_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] pattern
);
    logic [DATA_W-1:0] base_tbl [BASE_PAT];
    logic [SEL_W-1:0]  sel;
    logic              inv;

    // Base pattern k: data bit b equals bit k of b's index.
    for (genvar k = 0; k < BASE_PAT; k++) begin : g_row
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            assign base_tbl[k][b] = 1'((b >> k) & 1);
        end
    end

    always_comb begin
        inv = (idx >= IDX_W'(BASE_PAT));
        sel = inv ? SEL_W'(idx - IDX_W'(BASE_PAT)) : SEL_W'(idx);
        pattern = inv ? ~base_tbl[sel] : base_tbl[sel];
    end
endmodule

// File: rtl/dlt_fsm.sv
module dlt_fsm
    import dlt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              mem_rvalid,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              sel_filler,
    output logic [IDX_W-1:0]  pat_idx,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic              cmp_valid,
    output logic              clear,
    output logic              busy,
    output logic              done
);
    seq_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pat_idx  <= '0;
            tgt_addr <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    tgt_addr <= base_addr;
                    pat_idx  <= '0;
                    state    <= ST_WR_PAT;
                end
                ST_WR_PAT:  state <= ST_WR_FILL;
                ST_WR_FILL: state <= ST_RD_REQ;
                ST_RD_REQ:  state <= ST_RD_WAIT;
                ST_RD_WAIT: if (mem_rvalid) begin
                    if (pat_idx == IDX_W'(NUM_PAT - 1)) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        pat_idx <= pat_idx + 1'b1;
                        state   <= ST_WR_PAT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req    = (state == ST_WR_PAT) || (state == ST_WR_FILL) || (state == ST_RD_REQ);
        mem_we     = (state == ST_WR_PAT) || (state == ST_WR_FILL);
        sel_filler = (state == ST_WR_FILL);
        mem_addr   = sel_filler ? tgt_addr + 1'b1 : tgt_addr;
        cmp_valid  = (state == ST_RD_WAIT) && mem_rvalid;
        clear      = (state == ST_IDLE) && start;
        busy       = (state != ST_IDLE);
    end

    // R3
    rd_after_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> $past(mem_req && mem_we && (mem_addr == tgt_addr + 1'b1)));

    // R4
    no_req_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> !mem_req);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(mem_rvalid)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/dlt_capture.sv
module dlt_capture
    import dlt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              cmp_valid,
    input  cmp_pair_t         cmp,
    input  logic [ADDR_W-1:0] addr,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output cmp_pair_t         fail_data
);
    logic mismatch;
    assign mismatch = cmp_valid && (cmp.actual != cmp.expected);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_data <= '0;
        end else if (mismatch && !fail) begin
            fail      <= 1'b1;
            fail_addr <= addr;
            fail_data <= cmp;
        end
    end

    // R6
    fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (fail && !clear) |=> fail);

    // R7
    capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fail && !clear) |=> ($stable(fail_data) && $stable(fail_addr)));
endmodule

// File: rtl/dataline_tester.sv
module dataline_tester
    import dlt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [63:0]       fail_expected,
    output logic [63:0]       fail_actual,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata
);
    logic [IDX_W-1:0]  pat_idx;
    logic [DATA_W-1:0] pattern;
    logic [ADDR_W-1:0] tgt_addr;
    logic              sel_filler, cmp_valid, clear;
    cmp_pair_t         cmp, fail_data;

    dlt_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .mem_rvalid(mem_rvalid), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .sel_filler(sel_filler), .pat_idx(pat_idx),
        .tgt_addr(tgt_addr), .cmp_valid(cmp_valid), .clear(clear),
        .busy(busy), .done(done)
    );

    dlt_pattern_gen u_pat (.idx(pat_idx), .pattern(pattern));

    assign mem_wdata    = sel_filler ? FILLER_WORD : pattern;
    assign cmp.expected = pattern;
    assign cmp.actual   = mem_rdata;

    dlt_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst(rst), .clear(clear), .cmp_valid(cmp_valid),
        .cmp(cmp), .addr(tgt_addr), .fail(fail), .fail_addr(fail_addr),
        .fail_data(fail_data)
    );

    assign fail_expected = fail_data.expected;
    assign fail_actual   = fail_data.actual;
endmodule

// File: tb/dataline_tester_bench.sv
module dataline_tester_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam logic [63:0] FILL = 64'h0123456789ABCDEF;

    logic clk = 0, rst = 1, start = 0;
    logic [AW-1:0] base_addr = '0;
    logic busy, done, fail, mem_req, mem_we;
    logic [AW-1:0] fail_addr, mem_addr;
    logic [63:0] fail_expected, fail_actual, mem_wdata;
    logic mem_rvalid = 0;
    logic [63:0] mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dataline_tester #(.ADDR_W(AW)) u_dataline_tester (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
        .fail_expected(fail_expected), .fail_actual(fail_actual),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_pat(input int i);
        case (i)
            0: return 64'hAAAAAAAAAAAAAAAA;   1: return 64'hCCCCCCCCCCCCCCCC;
            2: return 64'hF0F0F0F0F0F0F0F0;   3: return 64'hFF00FF00FF00FF00;
            4: return 64'hFFFF0000FFFF0000;   5: return 64'hFFFFFFFF00000000;
            6: return 64'h5555555555555555;   7: return 64'h3333333333333333;
            8: return 64'h0F0F0F0F0F0F0F0F;   9: return 64'h00FF00FF00FF00FF;
            10: return 64'h0000FFFF0000FFFF;  default: return 64'h00000000FFFFFFFF;
        endcase
    endfunction

    // memory model with fault knobs
    logic [63:0] mem [256];
    logic [63:0] sa0 = '0, sa1 = '0, last_w = '0, pend_val = '0;
    bit floating = 0, rd_pend = 0;
    int rd_dly = 0, cnt = 0;

    always @(posedge clk) begin
        logic [63:0] v;
        mem_rvalid <= 1'b0;
        if (rd_pend) begin
            if (cnt == 0) begin mem_rvalid <= 1'b1; mem_rdata <= pend_val; rd_pend <= 0; end
            else cnt <= cnt - 1;
        end
        if (mem_req && mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            last_w <= mem_wdata;
        end
        if (mem_req && !mem_we) begin
            v = floating ? last_w : mem[mem_addr[7:0]];
            v = (v | sa1) & ~sa0;
            if (rd_dly == 0) begin mem_rvalid <= 1'b1; mem_rdata <= v; end
            else begin rd_pend <= 1; cnt <= rd_dly - 1; pend_val <= v; end
        end
    end

    // request monitor
    logic        op_we [64];
    logic [AW-1:0] op_addr [64];
    logic [63:0] op_data [64];
    int op_n = 0, done_cnt = 0, dbl_done = 0, busy_at_done = 0, req_while_rd = 0;
    int cyc = 0, last_rv_cyc = -10, done_gap_bad = 0;
    bit rd_out = 0, prev_done = 0;

    always @(posedge clk) begin
        cyc++;
        if (mem_rvalid) begin rd_out = 0; last_rv_cyc = cyc; end
        if (mem_req) begin
            if (rd_out) req_while_rd++;
            if (op_n < 64) begin
                op_we[op_n] = mem_we; op_addr[op_n] = mem_addr; op_data[op_n] = mem_wdata;
            end
            op_n++;
            if (!mem_we) rd_out = 1;
        end
        if (done) begin
            done_cnt++;
            if (busy) busy_at_done++;
            if (cyc != last_rv_cyc + 1) done_gap_bad++;
        end
        if (done && prev_done) dbl_done++;
        prev_done = done;
    end

    task automatic clear_mon();
        op_n = 0; done_cnt = 0; dbl_done = 0; busy_at_done = 0;
        req_while_rd = 0; done_gap_bad = 0;
    endtask

    task automatic pulse_start(input logic [AW-1:0] a);
        @(negedge clk); start = 1; base_addr = a;
        @(negedge clk); start = 0;
    endtask

    task automatic wait_done();
        int k;
        for (k = 0; k < 2000 && done_cnt == 0; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_sequence(input logic [AW-1:0] a, input string tag);
        chk(op_n == 36, "R5", {tag, " request count"}, 64'(op_n), 64'd36);
        for (int i = 0; i < 12 && op_n >= 36; i++) begin
            chk(op_we[3*i] && op_addr[3*i] == a && op_data[3*i] == exp_pat(i),
                "R2", {tag, " pattern write"}, op_data[3*i], exp_pat(i));
            chk(op_we[3*i+1] && op_addr[3*i+1] == a + 1'b1 && op_data[3*i+1] == FILL,
                "R3", {tag, " filler write"}, op_data[3*i+1], FILL);
            chk(!op_we[3*i+2] && op_addr[3*i+2] == a,
                "R3", {tag, " single read of target"}, 64'(op_addr[3*i+2]), 64'(a));
        end
        chk(done_cnt == 1 && dbl_done == 0, "R8", {tag, " one done pulse"}, 64'(done_cnt), 64'd1);
        chk(busy_at_done == 0, "R8", {tag, " busy low with done"}, 64'(busy_at_done), 64'd0);
        chk(done_gap_bad == 0, "R8", {tag, " done after last data"}, 64'(done_gap_bad), 64'd0);
        chk(req_while_rd == 0, "R4", {tag, " no request while read pending"}, 64'(req_while_rd), 64'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        repeat (4) @(negedge clk);
        chk(!busy && !done && !fail, "R1", "reset flags", {61'd0, busy, done, fail}, 64'd0);
        chk(fail_expected == 0 && fail_actual == 0 && fail_addr == 0, "R1", "reset capture",
            fail_actual, 64'd0);
        chk(op_n == 0, "R1", "no request before start", 64'(op_n), 64'd0);
    endtask

    task automatic t_clean();
        clear_mon(); sa0 = 0; sa1 = 0; floating = 0; rd_dly = 0;
        pulse_start(16'h0040);
        chk(busy, "R8", "busy after start", {63'd0, busy}, 64'd1);
        wait_done();
        check_sequence(16'h0040, "clean");
        chk(!fail, "R6", "clean run passes", {63'd0, fail}, 64'd0);
    endtask

    task automatic t_stuck_low();
        clear_mon(); sa0 = 64'h1; rd_dly = 1;
        pulse_start(16'h1234);
        wait_done();
        check_sequence(16'h1234, "stuck");
        chk(fail, "R6", "fail set on mismatch", {63'd0, fail}, 64'd1);
        chk(fail_addr == 16'h1234, "R7", "captured address", 64'(fail_addr), 64'h1234);
        chk(fail_expected == 64'h5555555555555555, "R7", "first failing pattern kept",
            fail_expected, 64'h5555555555555555);
        chk(fail_actual == 64'h5555555555555554, "R7", "first read value kept",
            fail_actual, 64'h5555555555555554);
        repeat (5) @(negedge clk);
        chk(fail, "R6", "fail holds while idle", {63'd0, fail}, 64'd1);
        sa0 = 0;
    endtask

    task automatic t_restart_clears();
        clear_mon(); rd_dly = 0;
        pulse_start(16'h0041);
        chk(!fail && fail_expected == 0, "R6", "start clears fail", {63'd0, fail}, 64'd0);
        wait_done();
        chk(!fail && fail_actual == 0, "R7", "capture cleared after clean rerun", fail_actual, 64'd0);
    endtask

    task automatic t_floating();
        clear_mon(); floating = 1; rd_dly = 3;
        pulse_start(16'h00FF);
        wait_done();
        check_sequence(16'h00FF, "float");
        chk(fail && fail_expected == 64'hAAAAAAAAAAAAAAAA, "R7", "float expected",
            fail_expected, 64'hAAAAAAAAAAAAAAAA);
        chk(fail_actual == FILL, "R3", "float reads filler", fail_actual, FILL);
        floating = 0;
    endtask

    task automatic t_start_busy();
        clear_mon(); rd_dly = 0;
        pulse_start(16'h0010);
        base_addr = 16'h0777;
        repeat (10) @(negedge clk);
        pulse_start(16'h0700);
        base_addr = 16'h0333;
        wait_done();
        repeat (5) @(negedge clk);
        check_sequence(16'h0010, "busy-start R9 R10");
        chk(!busy, "R9", "no second run", {63'd0, busy}, 64'd0);
    endtask

    initial begin
        t_reset();
        t_clean();
        t_stuck_low();
        t_restart_clears();
        t_floating();
        t_start_busy();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R8 watchdog expired actual=hang expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule